// File: doc/BRIEF.md
# System Clock Divider with Power-Save and Power-Down

This block derives the system clock from an input clock that runs at twice the wanted rate. In the plain mode it hands out a square wave at half the input frequency. Software can pick a slower power-save rate with a two-bit select written through a one-cycle write strobe. In that mode the system clock is divided once more by 4, 8 or 16. Any interrupt returns the block to the plain rate.

A halt indication asks for power-down. The output clock finishes its current period and then stays low until an interrupt arrives. When the interrupt comes, the clock restarts at the plain rate. Every change of rate or state waits for the end of a full output period, so the output never shows a shortened high or low phase. A two-stage synchronizer for a ready input advances only on the rising edges of the generated clock. Its output therefore follows the system clock timing and freezes while the clock is stopped.

All registers run on the input clock with a synchronous, active-high reset. The generated clock leaves the block as a registered signal.

Top module: `sysclk_pwrctl`

## Requirements
- R1: While reset is asserted, `sys_clk` and `rdy_sync` are low. On the first input clock edge after reset is released, `sys_clk` goes high and the plain rate is in force.
- R2: In the plain rate, each high phase and each low phase of `sys_clk` lasts exactly one input clock cycle.
- R3: A write with `ps_wr` high loads `ps_sel`, which selects the phase length in input cycles:
  - 2'b00: plain rate, phase length 1.
  - 2'b01: phase length 4 (system clock divided by 4).
  - 2'b10: phase length 8.
  - 2'b11: phase length 16.
- R4: A new phase length is adopted only at a rising edge of `sys_clk`. Every high phase lasts 1, 4, 8 or 16 cycles, and no low phase is shorter than the high phase before it.
- R5: An `irq` pulse returns the select to plain. Writing 2'b00 does the same. Either way, the period already running is completed first.
- R6: When `irq` and `ps_wr` are high in the same cycle, the interrupt wins and the write is ignored.
- R7: A pulse on `halt` makes `sys_clk` stay low from the end of the period in progress until an interrupt.
- R8: In the stopped state, an `irq` sampled on edge k makes `sys_clk` rise on edge k+1. The clock then runs at the plain rate.
- R9: When `halt` and `irq` are high in the same cycle, no stop occurs.
- R10: `rdy_sync` takes the value `rdy_in` had at the rising edge of `sys_clk` before the previous one. It changes only at rising edges of `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Double-rate input clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_wr | input | 1 | Write strobe for the power-save select |
| ps_sel | input | 2 | Power-save select value written on `ps_wr` |
| halt | input | 1 | Halt indication, requests power-down |
| irq | input | 1 | Interrupt, leaves power-save and power-down |
| rdy_in | input | 1 | Asynchronous ready input |
| sys_clk | output | 1 | Generated system clock |
| rdy_sync | output | 1 | Ready input after two system-clock stages |

## Verification
The checker assumes that `ps_wr`, `halt` and `irq` are single-cycle, synchronous pulses that are well defined after reset. It relies on that when it relates a write or a halt to the request state one edge later. The stimulus drives every input on the falling edge of the input clock and holds each strobe high for one cycle. That covers the random select writes, the deliberate overlaps of interrupt with write and with halt, and the halts issued in the middle of slow periods. The ready input changes only on falling edges, so the synchronizer model never sees a value that is changing at a sampling edge.

// File: rtl/sysclk_pwr_pkg.sv
package sysclk_pwr_pkg;

    localparam int MAX_HALF = 16;
    localparam int CNT_W    = $clog2(MAX_HALF);
    localparam int HALF_W   = CNT_W + 1;

    typedef enum logic [1:0] {
        PS_OFF   = 2'b00,
        PS_DIV4  = 2'b01,
        PS_DIV8  = 2'b10,
        PS_DIV16 = 2'b11
    } ps_sel_e;

    typedef enum logic {
        RUN_ST  = 1'b0,
        STOP_ST = 1'b1
    } run_st_e;

    typedef struct packed {
        run_st_e             st;
        logic                lvl;
        logic [CNT_W-1:0]    cnt;
        logic [HALF_W-1:0]   half;
    } phase_t;

    // Input cycles per output phase for a select value.
    function automatic logic [HALF_W-1:0] half_of(ps_sel_e s);
        case (s)
            PS_DIV4:  half_of = HALF_W'(4);
            PS_DIV8:  half_of = HALF_W'(8);
            PS_DIV16: half_of = HALF_W'(16);
            default:  half_of = HALF_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/sysclk_ps_ctrl.sv
module sysclk_ps_ctrl
    import sysclk_pwr_pkg::*;
(
    input  logic       clk_in,
    input  logic       rst,
    input  logic       ps_wr,
    input  logic [1:0] ps_sel,
    input  logic       halt,
    input  logic       irq,
    output ps_sel_e    sel_q,
    output logic       pd_req
);

    always_ff @(posedge clk_in) begin
        if (rst || irq) begin
            sel_q  <= PS_OFF;
            pd_req <= 1'b0;
        end else begin
            if (ps_wr) begin
                sel_q <= ps_sel_e'(ps_sel);
            end
            if (halt) begin
                pd_req <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysclk_phase_gen.sv
module sysclk_phase_gen
    import sysclk_pwr_pkg::*;
(
    input  logic                clk_in,
    input  logic                rst,
    input  ps_sel_e             sel,
    input  logic                pd_req,
    output logic                lvl,
    output logic                rise_tick,
    output logic                stopped,
    output logic [HALF_W-1:0]   half
);

    phase_t cur, nxt;
    logic   at_end;

    assign at_end = ({1'b0, cur.cnt} == (cur.half - HALF_W'(1)));

    always_comb begin
        nxt       = cur;
        rise_tick = 1'b0;
        case (cur.st)
            RUN_ST: begin
                if (at_end) begin
                    nxt.cnt = '0;
                    if (cur.lvl) begin
                        nxt.lvl = 1'b0;
                    end else if (pd_req) begin
                        nxt.st = STOP_ST;
                    end else begin
                        nxt.lvl   = 1'b1;
                        nxt.half  = half_of(sel);
                        rise_tick = 1'b1;
                    end
                end else begin
                    nxt.cnt = cur.cnt + CNT_W'(1);
                end
            end
            default: begin
                if (!pd_req) begin
                    nxt.st    = RUN_ST;
                    nxt.lvl   = 1'b1;
                    nxt.cnt   = '0;
                    nxt.half  = half_of(sel);
                    rise_tick = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_in) begin
        if (rst) begin
            cur.st   <= RUN_ST;
            cur.lvl  <= 1'b0;
            cur.cnt  <= '0;
            cur.half <= HALF_W'(1);
        end else begin
            cur <= nxt;
        end
    end

    assign lvl     = cur.lvl;
    assign stopped = (cur.st == STOP_ST);
    assign half    = cur.half;

endmodule

// File: rtl/sysclk_rdy_sync.sv
module sysclk_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_in,
    input  logic rst,
    input  logic adv,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_in) begin
                if (rst)      chain <= '0;
                else if (adv) chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk_in) begin
                if (rst)      chain <= '0;
                else if (adv) chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/sysclk_pwrctl.sv
module sysclk_pwrctl
    import sysclk_pwr_pkg::*;
#(
    parameter int RDY_STAGES = 2
) (
    input  logic       clk_in,
    input  logic       rst,
    input  logic       ps_wr,
    input  logic [1:0] ps_sel,
    input  logic       halt,
    input  logic       irq,
    input  logic       rdy_in,
    output logic       sys_clk,
    output logic       rdy_sync
);

    ps_sel_e             sel_q;
    logic                pd_req;
    logic                rise_tick;
    logic                stopped;
    logic [HALF_W-1:0]   half;

    sysclk_ps_ctrl u_ctrl (
        .clk_in (clk_in),
        .rst    (rst),
        .ps_wr  (ps_wr),
        .ps_sel (ps_sel),
        .halt   (halt),
        .irq    (irq),
        .sel_q  (sel_q),
        .pd_req (pd_req)
    );

    sysclk_phase_gen u_phase (
        .clk_in    (clk_in),
        .rst       (rst),
        .sel       (sel_q),
        .pd_req    (pd_req),
        .lvl       (sys_clk),
        .rise_tick (rise_tick),
        .stopped   (stopped),
        .half      (half)
    );

    sysclk_rdy_sync #(.STAGES(RDY_STAGES)) u_rdy (
        .clk_in (clk_in),
        .rst    (rst),
        .adv    (rise_tick),
        .din    (rdy_in),
        .dout   (rdy_sync)
    );

endmodule

// File: rtl/sysclk_pwrctl_chk.sv
module sysclk_pwrctl_chk
    import sysclk_pwr_pkg::*;
(
    input logic                clk_in,
    input logic                rst,
    input logic                ps_wr,
    input logic [1:0]          ps_sel,
    input logic                halt,
    input logic                irq,
    input logic                sys_clk,
    input logic                rdy_sync,
    input ps_sel_e             sel_q,
    input logic                pd_req,
    input logic                stopped,
    input logic [HALF_W-1:0]   half
);

    // R7
    stop_holds_low_chk: assert property (@(posedge clk_in) disable iff (rst)
        stopped |-> !sys_clk);

    // R3
    sel_write_chk: assert property (@(posedge clk_in) disable iff (rst)
        (ps_wr && !irq) |=> (sel_q == ps_sel_e'($past(ps_sel))));

    // R6
    irq_wins_chk: assert property (@(posedge clk_in) disable iff (rst)
        irq |=> (sel_q == PS_OFF && !pd_req));

    // R9
    halt_irq_chk: assert property (@(posedge clk_in) disable iff (rst)
        (halt && irq) |=> !pd_req);

    // R4
    half_at_rise_chk: assert property (@(posedge clk_in) disable iff (rst)
        !$rose(sys_clk) |-> $stable(half));

    // R4
    half_legal_chk: assert property (@(posedge clk_in) disable iff (rst)
        $countones(half) == 1);

    // R10
    rdy_at_rise_chk: assert property (@(posedge clk_in) disable iff (rst)
        !$rose(sys_clk) |-> $stable(rdy_sync));

endmodule

bind sysclk_pwrctl sysclk_pwrctl_chk u_chk (
    .clk_in   (clk_in),
    .rst      (rst),
    .ps_wr    (ps_wr),
    .ps_sel   (ps_sel),
    .halt     (halt),
    .irq      (irq),
    .sys_clk  (sys_clk),
    .rdy_sync (rdy_sync),
    .sel_q    (sel_q),
    .pd_req   (pd_req),
    .stopped  (stopped),
    .half     (half)
);

// File: tb/sysclk_pwrctl_test.sv
module sysclk_pwrctl_test;

    localparam time CLK_PER = 10ns;
    localparam int  WDOG    = 100000;

    logic       clk_in = 1'b0;
    logic       rst    = 1'b1;
    logic       ps_wr  = 1'b0;
    logic [1:0] ps_sel = 2'b00;
    logic       halt   = 1'b0;
    logic       irq    = 1'b0;
    logic       rdy_in = 1'b0;
    logic       sys_clk;
    logic       rdy_sync;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit mon_en = 1'b0;

    sysclk_pwrctl uut (
        .clk_in   (clk_in),
        .rst      (rst),
        .ps_wr    (ps_wr),
        .ps_sel   (ps_sel),
        .halt     (halt),
        .irq      (irq),
        .rdy_in   (rdy_in),
        .sys_clk  (sys_clk),
        .rdy_sync (rdy_sync)
    );

    always #(CLK_PER/2) clk_in = ~clk_in;

    function automatic int exp_half(logic [1:0] s);
        case (s)
            2'b01:   return 4;
            2'b10:   return 8;
            2'b11:   return 16;
            default: return 1;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk_in) begin
        cycles++;
        if (cycles > WDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG);
            finish_run();
        end
    end

    // R4 phase monitor: high phases legal, low never shorter than preceding high
    int  run_len = 0;
    int  prev_high = 0;
    int  primed = 0;
    bit  last_lvl = 1'b0;
    always @(negedge clk_in) begin
        if (!mon_en) begin
            primed = 0; run_len = 0; prev_high = 0; last_lvl = sys_clk;
        end else if (sys_clk == last_lvl) begin
            run_len++;
        end else begin
            if (primed > 0) begin
                if (last_lvl)
                    check(run_len == 1 || run_len == 4 || run_len == 8 || run_len == 16,
                          "R4 high", run_len, 1);
                else if (prev_high > 0)
                    check(run_len >= prev_high, "R4 low", run_len, prev_high);
            end
            if (last_lvl && primed > 0) prev_high = run_len;
            primed++;
            last_lvl = sys_clk;
            run_len  = 1;
        end
    end

    task automatic wait_rise();
        @(negedge clk_in);
        while (sys_clk) @(negedge clk_in);
        while (!sys_clk) @(negedge clk_in);
    endtask

    task automatic measure(output int h, output int l);
        wait_rise();
        h = 1;
        @(negedge clk_in);
        while (sys_clk) begin h++; @(negedge clk_in); end
        l = 1;
        @(negedge clk_in);
        while (!sys_clk) begin l++; @(negedge clk_in); end
    endtask

    task automatic write_sel(logic [1:0] v, bit with_irq);
        @(negedge clk_in);
        ps_wr = 1'b1; ps_sel = v; irq = with_irq;
        @(negedge clk_in);
        ps_wr = 1'b0; irq = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk_in);
        irq = 1'b1;
        @(negedge clk_in);
        irq = 1'b0;
    endtask

    task automatic expect_rate(int hexp, string req);
        int h, l;
        measure(h, l);
        measure(h, l);
        check(h == hexp, req, h, hexp);
        check(l == hexp, req, l, hexp);
    endtask

    initial begin
        int h, l;
        bit held;
        void'($urandom(32'd5150));

        // R1 reset state
        repeat (3) @(negedge clk_in);
        check(sys_clk == 1'b0, "R1 clk in reset", sys_clk, 0);
        check(rdy_sync == 1'b0, "R1 rdy in reset", rdy_sync, 0);
        rst = 1'b0;
        @(negedge clk_in);
        check(sys_clk == 1'b1, "R1 first rise", sys_clk, 1);
        mon_en = 1'b1;

        // R2 plain rate
        expect_rate(1, "R2 plain");

        // R3 directed selects
        write_sel(2'b01, 1'b0); expect_rate(4, "R3 div4");
        write_sel(2'b11, 1'b0); expect_rate(16, "R3 div16");
        write_sel(2'b10, 1'b0); expect_rate(8, "R3 div8");

        // R5 write 00 returns to plain
        write_sel(2'b00, 1'b0); expect_rate(1, "R5 write off");

        // R3 R4 random selects
        for (int i = 0; i < 10; i++) begin
            logic [1:0] s;
            s = 2'($urandom % 4);
            write_sel(s, 1'b0);
            expect_rate(exp_half(s), "R3 random");
        end

        // R5 irq leaves power-save mid-period
        write_sel(2'b11, 1'b0);
        wait_rise();
        repeat (5) @(negedge clk_in);
        pulse_irq();
        expect_rate(1, "R5 irq exit");

        // R6 irq wins over write
        write_sel(2'b10, 1'b1);
        expect_rate(1, "R6 irq vs write");

        // R7 halt in plain: stops low
        @(negedge clk_in); halt = 1'b1;
        @(negedge clk_in); halt = 1'b0;
        repeat (4) @(negedge clk_in);
        held = 1'b1;
        for (int i = 0; i < 30; i++) begin
            if (sys_clk) held = 1'b0;
            @(negedge clk_in);
        end
        check(held, "R7 stopped low", held, 1);

        // R10 ready frozen while stopped
        rdy_in = 1'b1;
        repeat (10) @(negedge clk_in);
        check(rdy_sync == 1'b0, "R10 frozen", rdy_sync, 0);
        rdy_in = 1'b0;

        // R8 wake timing
        irq = 1'b1;
        @(negedge clk_in);
        irq = 1'b0;
        check(sys_clk == 1'b0, "R8 one edge after irq", sys_clk, 0);
        @(negedge clk_in);
        check(sys_clk == 1'b1, "R8 rise", sys_clk, 1);
        expect_rate(1, "R8 plain after wake");

        // R7 halt in div16: period completes, then stop; wake to plain
        write_sel(2'b11, 1'b0);
        wait_rise();
        repeat (3) @(negedge clk_in);
        halt = 1'b1;
        @(negedge clk_in); halt = 1'b0;
        repeat (40) @(negedge clk_in);
        held = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (sys_clk) held = 1'b0;
            @(negedge clk_in);
        end
        check(held, "R7 stop after slow period", held, 1);
        pulse_irq();
        expect_rate(1, "R8 wake from slow");

        // R9 halt with irq: no stop
        @(negedge clk_in); halt = 1'b1; irq = 1'b1;
        @(negedge clk_in); halt = 1'b0; irq = 1'b0;
        measure(h, l);
        check(h == 1 && l == 1, "R9 no stop", l, 1);

        // R10 two-stage sync on system clock rises
        wait_rise();
        rdy_in = 1'b1;
        wait_rise();
        check(rdy_sync == 1'b0, "R10 first rise", rdy_sync, 0);
        wait_rise();
        check(rdy_sync == 1'b1, "R10 second rise", rdy_sync, 1);
        write_sel(2'b01, 1'b0);
        wait_rise();
        rdy_in = 1'b0;
        wait_rise();
        check(rdy_sync == 1'b1, "R10 slow first", rdy_sync, 1);
        wait_rise();
        check(rdy_sync == 1'b0, "R10 slow second", rdy_sync, 0);

        mon_en = 1'b0;
        finish_run();
    end

endmodule